// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

The controller holds a bit-addressable array of one-time-programmable storage. The array is split into `SECTIONS` equal sections of `SECTION_BITS` bits each, and every section is stored as 32-bit rows. A bit address selects row `addr / 32` and bit `addr % 32` inside that row. A single request port accepts four operations. Program sets one bit. Read-bit returns one bit. Read-row returns the whole 32-bit row that holds the addressed bit. Validate checks the 4-bit marker field in the first row of every section and returns one valid bit per section.

Once set, a bit stays set. The parameter list `PROT_LIST` names bit addresses that refuse programming. When `AUTO_INIT` is set, a marker field found all-zero during validation is written with the valid pattern before it is judged. After reset the controller clears the array one row per cycle and holds `busy` high until it is done, so the storage can map onto block RAM without a reset port.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: While reset is high and during the clearing sweep after it, `resp_valid` stays low and `busy` is high. After the sweep every row reads back as zero.
- R2: Program (op 0) to an in-range address that is not protected sets bit `addr % 32` of row `addr / 32` and answers `resp_ok`=1. No other bit of the array changes.
- R3: Program never clears a bit. Programming a bit that is already set leaves the array unchanged and still answers `resp_ok`=1.
- R4: Program to an address listed in `PROT_LIST` (default 5, 2100, 4200) answers `resp_ok`=0 and `resp_err`=0, and the array is unchanged.
- R5: A program, read-bit or read-row request with `addr >= SECTIONS*SECTION_BITS` answers `resp_err`=1 and `resp_ok`=0, and the array is unchanged.
- R6: Read-bit (op 1) answers `resp_ok`=1, with `resp_bit` set to the stored value of the addressed bit.
- R7: Read-row (op 2) answers `resp_ok`=1, with `resp_row` set to the full row `addr / 32`.
- R8: Validate (op 3) ignores `addr`. It answers `resp_ok`=1, and bit i of `resp_mask` is 1 exactly when bits 31..28 of the first row of section i (row `i*SECTION_BITS/32`) hold 4'b1010 after the step in R9.
- R9: With `AUTO_INIT`=1, validation writes 4'b1010 into a marker field that is 4'b0000 and reports that section valid. A non-zero wrong marker is left unchanged and reported invalid.
- R10: A request is taken only in a cycle where `busy` is low, and a request presented while `busy` is high is ignored. Each accepted request produces exactly one one-cycle `resp_valid` pulse. Program and read answer one cycle after acceptance and validate answers `SECTIONS` cycles after it. A rejected request (R4, R5) answers in the cycle right after the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 2 | 0 program, 1 read bit, 2 read row, 3 validate |
| req_addr | input | ADDR_W | Bit address |
| busy | output | 1 | Clearing or a multi-cycle operation is in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_ok | output | 1 | Operation succeeded |
| resp_err | output | 1 | Address beyond the array |
| resp_bit | output | 1 | Read-bit result |
| resp_row | output | 32 | Read-row result |
| resp_mask | output | SECTIONS | Per-section marker valid mask |

## Verification
The assertions assume that `req_op` and `req_addr` are known whenever `req_valid` is high, and that nothing is expected from a request made while `busy` is high. The stimulus drives requests only at the falling edge. It waits for `busy` to drop before every request, except for one directed case that raises a program request on purpose during a validation. Random addresses mostly fall inside the array, and about one in eight is taken from the protected list, so the reject path is exercised without running out of programmable bits.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

  localparam int ROW_W    = 32;
  localparam int BIT_AW   = 5;
  localparam int MARK_LSB = 28;
  localparam int MARK_W   = 4;
  localparam logic [MARK_W-1:0] MARK_PAT = 4'b1010;

  typedef enum logic [1:0] {
    OP_PROGRAM  = 2'd0,
    OP_READ_BIT = 2'd1,
    OP_READ_ROW = 2'd2,
    OP_VALIDATE = 2'd3
  } fuse_op_e;

  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_READ,
    ST_PROG,
    ST_VAL
  } fuse_state_e;

endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int ROWS  = 192,
  parameter int WIDTH = 32,
  localparam int AW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [ROWS];

  // simple dual-port, registered read, no reset: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/otp_fuse_protect.sv
module otp_fuse_protect #(
  parameter int ADDR_W     = 14,
  parameter int PROT_COUNT = 3,
  parameter logic [PROT_COUNT*32-1:0] PROT_LIST = {32'd4200, 32'd2100, 32'd5}
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  logic [PROT_COUNT-1:0] match;
  logic [31:0]           addr_ext;

  assign addr_ext = 32'(addr);

  for (genvar g = 0; g < PROT_COUNT; g++) begin : g_cmp
    assign match[g] = (addr_ext == PROT_LIST[g*32 +: 32]);
  end

  assign hit = |match;

endmodule

// File: rtl/otp_fuse_seq.sv
module otp_fuse_seq
  import otp_fuse_pkg::*;
#(
  parameter int SECTIONS     = 3,
  parameter int SECTION_BITS = 2048,
  parameter bit AUTO_INIT    = 1'b1,
  localparam int TOTAL_BITS  = SECTIONS * SECTION_BITS,
  localparam int ROWS        = TOTAL_BITS / ROW_W,
  localparam int ROWS_PER_SEC = SECTION_BITS / ROW_W,
  localparam int ROW_AW      = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int ADDR_W      = $clog2(TOTAL_BITS) + 1,
  localparam int SEC_W       = (SECTIONS > 1) ? $clog2(SECTIONS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [1:0]          req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                prot_hit,
  output logic                busy,
  output logic                clearing,
  output logic                ram_we,
  output logic [ROW_AW-1:0]   ram_waddr,
  output logic [ROW_W-1:0]    ram_wdata,
  output logic                ram_re,
  output logic [ROW_AW-1:0]   ram_raddr,
  input  logic [ROW_W-1:0]    ram_rdata,
  output logic                resp_valid,
  output logic                resp_ok,
  output logic                resp_err,
  output logic                resp_bit,
  output logic [ROW_W-1:0]    resp_row,
  output logic [SECTIONS-1:0] resp_mask
);

  fuse_state_e         state;
  fuse_op_e            op_in;
  logic [ROW_AW-1:0]   clr_row;
  logic [ROW_AW-1:0]   row_q;
  logic [BIT_AW-1:0]   bit_q;
  logic [SEC_W-1:0]    sec_q;
  logic [ROW_AW-1:0]   vrow_q;
  logic [SECTIONS-1:0] mask_q;

  logic                accept;
  logic                in_range;
  logic [ROW_AW-1:0]   req_row;
  logic [BIT_AW-1:0]   req_bit;
  logic [MARK_W-1:0]   nib;
  logic                nib_blank;
  logic                sec_valid;
  logic                sec_last;
  logic [SECTIONS-1:0] mask_next;

  assign op_in    = fuse_op_e'(req_op);
  assign accept   = (state == ST_IDLE) && req_valid;
  assign in_range = (32'(req_addr) < 32'(TOTAL_BITS));
  assign req_row  = req_addr[ROW_AW+BIT_AW-1:BIT_AW];
  assign req_bit  = req_addr[BIT_AW-1:0];

  assign busy     = (state != ST_IDLE);
  assign clearing = (state == ST_CLEAR);

  assign nib       = ram_rdata[MARK_LSB +: MARK_W];
  assign nib_blank = (nib == '0);
  assign sec_valid = (nib == MARK_PAT) || (AUTO_INIT && nib_blank);
  assign sec_last  = (sec_q == SEC_W'(SECTIONS - 1));
  assign mask_next = mask_q | (SECTIONS'(sec_valid) << sec_q);

  // memory control
  always_comb begin
    ram_re    = 1'b0;
    ram_raddr = '0;
    ram_we    = 1'b0;
    ram_waddr = '0;
    ram_wdata = '0;
    unique case (state)
      ST_CLEAR: begin
        ram_we    = 1'b1;
        ram_waddr = clr_row;
      end
      ST_IDLE: begin
        if (accept) begin
          unique case (op_in)
            OP_PROGRAM: begin
              ram_re    = in_range && !prot_hit;
              ram_raddr = req_row;
            end
            OP_READ_BIT, OP_READ_ROW: begin
              ram_re    = in_range;
              ram_raddr = req_row;
            end
            OP_VALIDATE: begin
              ram_re    = 1'b1;
              ram_raddr = '0;
            end
            default: ;
          endcase
        end
      end
      ST_PROG: begin
        ram_we    = 1'b1;
        ram_waddr = row_q;
        ram_wdata = ram_rdata | (ROW_W'(1) << bit_q);
      end
      ST_VAL: begin
        if (!sec_last) begin
          ram_re    = 1'b1;
          ram_raddr = vrow_q + ROW_AW'(ROWS_PER_SEC);
        end
        if (AUTO_INIT && nib_blank) begin
          ram_we    = 1'b1;
          ram_waddr = vrow_q;
          ram_wdata = ram_rdata;
          ram_wdata[MARK_LSB +: MARK_W] = MARK_PAT;
        end
      end
      default: ;
    endcase
  end

  // control state and registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_CLEAR;
      clr_row    <= '0;
      row_q      <= '0;
      bit_q      <= '0;
      sec_q      <= '0;
      vrow_q     <= '0;
      mask_q     <= '0;
      resp_valid <= 1'b0;
      resp_ok    <= 1'b0;
      resp_err   <= 1'b0;
      resp_bit   <= 1'b0;
      resp_row   <= '0;
      resp_mask  <= '0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state)
        ST_CLEAR: begin
          clr_row <= clr_row + 1'b1;
          if (clr_row == ROW_AW'(ROWS - 1)) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (accept) begin
            row_q     <= req_row;
            bit_q     <= req_bit;
            resp_ok   <= 1'b0;
            resp_err  <= 1'b0;
            resp_bit  <= 1'b0;
            resp_row  <= '0;
            resp_mask <= '0;
            unique case (op_in)
              OP_PROGRAM: begin
                if (!in_range) begin
                  resp_valid <= 1'b1;
                  resp_err   <= 1'b1;
                end else if (prot_hit) begin
                  resp_valid <= 1'b1;
                end else begin
                  state <= ST_PROG;
                end
              end
              OP_READ_BIT, OP_READ_ROW: begin
                if (!in_range) begin
                  resp_valid <= 1'b1;
                  resp_err   <= 1'b1;
                end else begin
                  state <= ST_READ;
                end
              end
              OP_VALIDATE: begin
                state  <= ST_VAL;
                sec_q  <= '0;
                vrow_q <= '0;
                mask_q <= '0;
              end
              default: ;
            endcase
          end
        end
        ST_READ: begin
          resp_valid <= 1'b1;
          resp_ok    <= 1'b1;
          resp_row   <= ram_rdata;
          resp_bit   <= ram_rdata[bit_q];
          state      <= ST_IDLE;
        end
        ST_PROG: begin
          resp_valid <= 1'b1;
          resp_ok    <= 1'b1;
          state      <= ST_IDLE;
        end
        ST_VAL: begin
          if (sec_last) begin
            resp_valid <= 1'b1;
            resp_ok    <= 1'b1;
            resp_mask  <= mask_next;
            state      <= ST_IDLE;
          end else begin
            sec_q  <= sec_q + 1'b1;
            vrow_q <= vrow_q + ROW_AW'(ROWS_PER_SEC);
            mask_q <= mask_next;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int SECTIONS     = 3,
  parameter int SECTION_BITS = 2048,
  parameter bit AUTO_INIT    = 1'b1,
  parameter int PROT_COUNT   = 3,
  parameter logic [PROT_COUNT*32-1:0] PROT_LIST = {32'd4200, 32'd2100, 32'd5},
  localparam int TOTAL_BITS  = SECTIONS * SECTION_BITS,
  localparam int ROWS        = TOTAL_BITS / ROW_W,
  localparam int ROW_AW      = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int ADDR_W      = $clog2(TOTAL_BITS) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [1:0]          req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                busy,
  output logic                resp_valid,
  output logic                resp_ok,
  output logic                resp_err,
  output logic                resp_bit,
  output logic [31:0]         resp_row,
  output logic [SECTIONS-1:0] resp_mask
);

  logic              prot_hit;
  logic              clearing;
  logic              ram_we;
  logic [ROW_AW-1:0] ram_waddr;
  logic [ROW_W-1:0]  ram_wdata;
  logic              ram_re;
  logic [ROW_AW-1:0] ram_raddr;
  logic [ROW_W-1:0]  ram_rdata;

  otp_fuse_protect #(
    .ADDR_W    (ADDR_W),
    .PROT_COUNT(PROT_COUNT),
    .PROT_LIST (PROT_LIST)
  ) u_prot (
    .addr(req_addr),
    .hit (prot_hit)
  );

  otp_fuse_array #(
    .ROWS (ROWS),
    .WIDTH(ROW_W)
  ) u_array (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .re   (ram_re),
    .raddr(ram_raddr),
    .rdata(ram_rdata)
  );

  otp_fuse_seq #(
    .SECTIONS    (SECTIONS),
    .SECTION_BITS(SECTION_BITS),
    .AUTO_INIT   (AUTO_INIT)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .prot_hit  (prot_hit),
    .busy      (busy),
    .clearing  (clearing),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata),
    .ram_re    (ram_re),
    .ram_raddr (ram_raddr),
    .ram_rdata (ram_rdata),
    .resp_valid(resp_valid),
    .resp_ok   (resp_ok),
    .resp_err  (resp_err),
    .resp_bit  (resp_bit),
    .resp_row  (resp_row),
    .resp_mask (resp_mask)
  );

endmodule

// File: rtl/otp_fuse_chk.sv
module otp_fuse_chk #(
  parameter int SECTIONS     = 3,
  parameter int SECTION_BITS = 2048,
  localparam int TOTAL_BITS  = SECTIONS * SECTION_BITS,
  localparam int ADDR_W      = $clog2(TOTAL_BITS) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              busy,
  input logic              resp_valid,
  input logic              resp_ok,
  input logic              resp_err,
  input logic              clearing,
  input logic              prot_hit,
  input logic              ram_we,
  input logic [31:0]       ram_wdata,
  input logic [31:0]       ram_rdata
);

  logic taken;
  logic beyond;
  assign taken  = req_valid && !busy;
  assign beyond = (32'(req_addr) >= 32'(TOTAL_BITS));

  // R1
  clear_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    clearing |-> (busy && !resp_valid));

  // R3
  keep_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_we && !clearing) |-> ((ram_wdata & ram_rdata) == ram_rdata));

  // R2
  few_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_we && !clearing) |-> ($countones(ram_wdata ^ ram_rdata) <= 2));

  // R4
  prot_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (taken && req_op == 2'd0 && prot_hit && !beyond) |=>
      (resp_valid && !resp_ok && !resp_err));

  // R5
  range_err_chk: assert property (@(posedge clk) disable iff (rst)
    (taken && req_op != 2'd3 && beyond) |=> (resp_valid && resp_err && !resp_ok));

  // R10
  done_resp_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(clearing)) |-> resp_valid);

endmodule

bind otp_fuse_ctrl otp_fuse_chk #(
  .SECTIONS    (SECTIONS),
  .SECTION_BITS(SECTION_BITS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .busy      (busy),
  .resp_valid(resp_valid),
  .resp_ok   (resp_ok),
  .resp_err  (resp_err),
  .clearing  (clearing),
  .prot_hit  (prot_hit),
  .ram_we    (ram_we),
  .ram_wdata (ram_wdata),
  .ram_rdata (ram_rdata)
);

// File: tb/otp_fuse_ctrl_test.sv
module otp_fuse_ctrl_test;

  localparam int CLK_PERIOD   = 10;
  localparam int SECTIONS     = 3;
  localparam int SECTION_BITS = 2048;
  localparam int TOTAL        = SECTIONS * SECTION_BITS;
  localparam int ROWS         = TOTAL / 32;
  localparam int RPS          = SECTION_BITS / 32;
  localparam int ADDR_W       = $clog2(TOTAL) + 1;
  localparam int NPROT        = 3;
  localparam logic [NPROT*32-1:0] PLIST = {32'd4200, 32'd2100, 32'd5};

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                req_valid = 1'b0;
  logic [1:0]          req_op = '0;
  logic [ADDR_W-1:0]   req_addr = '0;
  logic                busy, resp_valid, resp_ok, resp_err, resp_bit;
  logic [31:0]         resp_row;
  logic [SECTIONS-1:0] resp_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] mdl [ROWS];
  logic        r_ok, r_err, r_bit;
  logic [31:0] r_row;
  logic [SECTIONS-1:0] r_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_fuse_ctrl #(
    .SECTIONS(SECTIONS), .SECTION_BITS(SECTION_BITS), .AUTO_INIT(1'b1),
    .PROT_COUNT(NPROT), .PROT_LIST(PLIST)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .busy(busy), .resp_valid(resp_valid),
    .resp_ok(resp_ok), .resp_err(resp_err), .resp_bit(resp_bit),
    .resp_row(resp_row), .resp_mask(resp_mask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_prot(input int a);
    for (int i = 0; i < NPROT; i++)
      if (PLIST[i*32 +: 32] == 32'(a)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [SECTIONS-1:0] model_validate();
    logic [SECTIONS-1:0] m = '0;
    for (int s = 0; s < SECTIONS; s++) begin
      if (mdl[s*RPS][31:28] == 4'b0000) mdl[s*RPS][31:28] = 4'b1010;
      m[s] = (mdl[s*RPS][31:28] == 4'b1010);
    end
    return m;
  endfunction

  task automatic issue(input logic [1:0] op, input int addr);
    int n = 0;
    while (busy) @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = ADDR_W'(addr);
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid && n < 64) begin
      @(negedge clk);
      n++;
    end
    if (!resp_valid) chk("R10 response timeout", 32'd0, 32'd1);
    r_ok = resp_ok; r_err = resp_err; r_bit = resp_bit;
    r_row = resp_row; r_mask = resp_mask;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < ROWS; i++) mdl[i] = '0;
    repeat (4) @(negedge clk);
    chk("R1 resp_valid low in reset", 32'(resp_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy during clear", 32'(busy), 32'd1);
    while (busy) @(negedge clk);
    issue(2'd2, 0);          chk("R1 row 0 cleared", r_row, 32'h0);
    issue(2'd2, TOTAL - 1);  chk("R1 last row cleared", r_row, 32'h0);

    // wrong marker in section 1 before first validation
    issue(2'd0, SECTION_BITS + 28);
    chk("R2 program ok", 32'(r_ok), 32'd1);
    mdl[RPS][28] = 1'b1;
    issue(2'd3, 0);
    chk("R8 R9 validate mask", 32'(r_mask), 32'(model_validate()));
    chk("R9 mask value", 32'(r_mask), 32'b101);
    issue(2'd2, 0);          chk("R9 auto marker written", r_row, 32'hA000_0000);
    issue(2'd2, SECTION_BITS); chk("R9 wrong marker kept", r_row, 32'h1000_0000);

    issue(2'd0, 32);  mdl[1][0] = 1'b1;
    issue(2'd0, 63);  mdl[1][31] = 1'b1;
    issue(2'd2, 40);  chk("R2 row 1 bits 0 and 31", r_row, 32'h8000_0001);
    issue(2'd0, 32);  chk("R3 reprogram ok", 32'(r_ok), 32'd1);
    issue(2'd2, 32);  chk("R3 row unchanged", r_row, 32'h8000_0001);
    issue(2'd1, 63);  chk("R6 read bit set", 32'(r_bit), 32'd1);
    issue(2'd1, 62);  chk("R6 read bit clear", 32'(r_bit), 32'd0);

    issue(2'd0, 5);
    chk("R4 protected ok low", 32'(r_ok), 32'd0);
    chk("R4 protected err low", 32'(r_err), 32'd0);
    issue(2'd2, 5);   chk("R4 row unchanged", r_row, mdl[0]);

    issue(2'd0, TOTAL);     chk("R5 program beyond err", 32'(r_err), 32'd1);
    chk("R5 program beyond ok", 32'(r_ok), 32'd0);
    issue(2'd2, (1 << ADDR_W) - 1); chk("R5 read beyond err", 32'(r_err), 32'd1);
    issue(2'd2, TOTAL - 1); chk("R5 last row untouched", r_row, mdl[ROWS-1]);

    // request while busy is ignored
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3; req_addr = '0;
    @(negedge clk);
    req_op = 2'd0; req_addr = ADDR_W'(3000);
    chk("R10 busy during validate", 32'(busy), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    chk("R10 mask after busy request", 32'(resp_mask), 32'(model_validate()));
    @(negedge clk);
    chk("R10 single pulse", 32'(resp_valid), 32'd0);
    issue(2'd1, 3000); chk("R10 ignored program", 32'(r_bit), 32'd0);

    for (int k = 0; k < 400; k++) begin
      int op = int'($urandom % 3);
      int a;
      if ($urandom % 8 == 0) a = int'(PLIST[($urandom % NPROT)*32 +: 32]);
      else a = int'($urandom % TOTAL);
      issue(2'(op), a);
      if (op == 0) begin
        chk("R2 R4 random program ok", 32'(r_ok), 32'(!is_prot(a)));
        if (!is_prot(a)) mdl[a/32][a%32] = 1'b1;
      end else if (op == 1) begin
        chk("R6 random bit", 32'(r_bit), 32'(mdl[a/32][a%32]));
      end else begin
        chk("R7 random row", r_row, mdl[a/32]);
      end
    end
    issue(2'd3, 0);
    chk("R8 final validate", 32'(r_mask), 32'(model_validate()));
    for (int s = 0; s < SECTIONS; s++) begin
      issue(2'd2, s * SECTION_BITS);
      chk("R7 R9 section head row", r_row, mdl[s*RPS]);
    end
    finish_run();
  end

endmodule